// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

The filter sits on the receive byte stream of an Ethernet MAC and decides, for each frame, whether the frame is kept. It reads only the six destination address octets. Each octet arrives on `octetData` with `octetValid`, and `sofIn` marks the first octet. While the octets arrive, the filter runs a CRC-32 over them and keeps a copy of the address.

One cycle after the sixth octet it raises a single-cycle `decisionValid` pulse together with `decisionAccept`. Five static mode inputs select the policy:

- Unicast destinations can be compared exactly against a station address.
- Unicast destinations can instead go through a 64-bin hash table, whose bin is chosen by the CRC.
- Group (multicast) destinations go through the same 64-bin hash table.
- Every group destination can be passed.
- Everything can be passed.
- The exact and hash comparisons can be inverted.

Frame storage, checking of the frame check sequence and register access belong to the surrounding logic. The station address and the hash words are plain inputs, expected to stay stable while a frame's address is received.

Top module: `dest_addr_filter`

## Requirements
- R1: When `octetValid` is high, `sofIn` high makes `octetData` address octet 0. The next five cycles with `octetValid` high deliver octets 1 to 5. Octets before the first `sofIn` after reset, and octets after the sixth, never cause a decision.
- R2: `decisionValid` is high for exactly one cycle, in the cycle after the clock edge that samples octet 5. `decisionAccept` is 0 whenever `decisionValid` is 0.
- R3: A `sofIn` in the middle of an address discards the partial address and CRC and starts a new address at octet 0.
- R4: The CRC starts at all ones and uses polynomial 0x04C11DB7. Each octet is shifted in bit 0 first, and the result is not inverted. The hash index is CRC bits 31:26. Index bit 5 set selects `hashHigh`, clear selects `hashLow`, and index bits 4:0 give the bit in that word.
- R5: A destination is a group address when bit 0 of octet 0 is 1. The all-ones broadcast address is always accepted.
- R6: With `modePromisc` set, every frame is accepted.
- R7: With `modeAllGroup` set, every group destination is accepted.
- R8: With all five mode inputs clear, non-broadcast group destinations are rejected. A unicast destination is accepted only when it equals `stationAddr`, with octet k compared to `stationAddr[8k+7:8k]`.
- R9: With `modeHashPerfect` set and `modeHashOnly` clear, unicast destinations use the exact compare and group destinations use the hash bin.
- R10: With `modeHashOnly` set, unicast destinations also use the hash bin instead of the exact compare.
- R11: `modeInvert` inverts the result of the exact compare and of the hash lookup. It does not change acceptance by promiscuous mode, by broadcast or by `modeAllGroup`. A group destination with neither hash mode set stays rejected.
- R12: After reset no decision is pending and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| octetValid | input | 1 | An address octet is present on `octetData` |
| sofIn | input | 1 | Marks the first octet of a frame (qualified by `octetValid`) |
| octetData | input | 8 | Received octet |
| stationAddr | input | 48 | Station unicast address, octet k in bits 8k+7:8k |
| hashHigh | input | 32 | Hash bins 32 to 63 |
| hashLow | input | 32 | Hash bins 0 to 31 |
| modePromisc | input | 1 | Accept every frame |
| modeAllGroup | input | 1 | Accept every group destination |
| modeHashPerfect | input | 1 | Hash for group destinations, exact compare for unicast |
| modeHashOnly | input | 1 | Hash for all destinations |
| modeInvert | input | 1 | Invert exact and hash outcomes |
| decisionValid | output | 1 | Single-cycle decision strobe |
| decisionAccept | output | 1 | Frame accepted, meaningful while `decisionValid` is high |

## Verification
The assertions check on every cycle the properties that hold for any address:

- the decision strobe is a single pulse that follows a received octet;
- the accept output is quiet outside the strobe;
- the octet counter stays in range;
- the captured address holds between octets;
- promiscuous, broadcast and pass-all-group acceptance override everything else;
- a group destination is rejected when no mode is set.

Only the bench's scenarios can show the rest. These are that the CRC selects the right hash bin, that the exact compare uses the right octet order, that inversion and hash-only mode combine correctly, and that restarts and stray octets are handled. The bench sweeps all 32 mode combinations against unicast, group and broadcast addresses and four hash tables, and runs one scan with a single hash bin set per group address.

// File: rtl/adf_pkg.sv
package adf_pkg;
  localparam int unsigned OCTET_W = 8;
  localparam int unsigned SLOT_W = 4;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;
    logic restart;
    logic last;
    logic [SLOT_W-1:0] slot;
  } adf_strobe_t;

  typedef struct packed {
    logic promisc;
    logic allGroup;
    logic hashPerfect;
    logic hashOnly;
    logic invert;
  } adf_mode_t;
endpackage

// File: rtl/adf_crc_step.sv
module adf_crc_step #(
  parameter int unsigned CRC_W = 32,
  parameter int unsigned DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = CRC_W'(adf_pkg::CRC_POLY)
) (
  input  logic [CRC_W-1:0]  crcIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcOut
);
  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = crcIn;

  // One shift stage per data bit, bit 0 first
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic fb;
    assign fb = chain[g][CRC_W-1] ^ dataIn[g];
    assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crcOut = chain[DATA_W];
endmodule

// File: rtl/adf_ctrl.sv
module adf_ctrl
  import adf_pkg::*;
#(
  parameter int unsigned ADDR_OCTETS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        octetValid,
  input  logic        sofIn,
  output adf_strobe_t strobe,
  output logic        decisionValid
);
  localparam int unsigned CNT_W = $clog2(ADDR_OCTETS + 1);

  logic [CNT_W-1:0] cntQ;
  logic             armed;
  logic             validQ;

  assign armed = cntQ < CNT_W'(ADDR_OCTETS);

  always_comb begin
    strobe = '0;
    if (octetValid && sofIn) begin
      strobe.load    = 1'b1;
      strobe.restart = 1'b1;
      strobe.slot    = '0;
    end else if (octetValid && armed) begin
      strobe.load = 1'b1;
      strobe.slot = SLOT_W'(cntQ);
    end
    strobe.last = strobe.load && (strobe.slot == SLOT_W'(ADDR_OCTETS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= CNT_W'(ADDR_OCTETS);
      validQ <= 1'b0;
    end else begin
      validQ <= strobe.last;
      if (strobe.load) cntQ <= CNT_W'(strobe.slot) + CNT_W'(1);
    end
  end

  assign decisionValid = validQ;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN) cntQ <= CNT_W'(ADDR_OCTETS)); // R1
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN) validQ |=> !validQ); // R2
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN) (!armed && !sofIn) |-> !strobe.load); // R1
endmodule

// File: rtl/adf_datapath.sv
module adf_datapath
  import adf_pkg::*;
#(
  parameter int unsigned ADDR_OCTETS = 6,
  parameter int unsigned HASH_WORD_W = 32,
  parameter int unsigned CRC_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  adf_strobe_t                     strobe,
  input  logic [OCTET_W-1:0]              octetIn,
  input  logic [ADDR_OCTETS*OCTET_W-1:0]  stationAddr,
  input  logic [HASH_WORD_W-1:0]          hashHigh,
  input  logic [HASH_WORD_W-1:0]          hashLow,
  output logic                            hashHit,
  output logic                            exactHit,
  output logic                            isGroup,
  output logic                            isBroadcast
);
  localparam int unsigned HASH_BINS = 2 * HASH_WORD_W;
  localparam int unsigned IDX_W = $clog2(HASH_BINS);

  logic [CRC_W-1:0] crcQ;
  logic [CRC_W-1:0] crcSeed;
  logic [CRC_W-1:0] crcNext;
  logic [ADDR_OCTETS-1:0][OCTET_W-1:0] addrQ;
  logic [HASH_BINS-1:0] hashTable;
  logic [IDX_W-1:0] hashIdx;

  assign crcSeed = strobe.restart ? '1 : crcQ;

  adf_crc_step #(
    .CRC_W(CRC_W),
    .DATA_W(OCTET_W)
  ) u_crc_step (
    .crcIn(crcSeed),
    .dataIn(octetIn),
    .crcOut(crcNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) crcQ <= '1;
    else if (strobe.load) crcQ <= crcNext;
  end

  // One capture register per address octet
  for (genvar g = 0; g < ADDR_OCTETS; g++) begin : g_octet
    always_ff @(posedge clk) begin
      if (!rstN) addrQ[g] <= '0;
      else if (strobe.load && strobe.slot == SLOT_W'(g)) addrQ[g] <= octetIn;
    end
  end

  assign hashTable   = {hashHigh, hashLow};
  assign hashIdx     = crcQ[CRC_W-1 -: IDX_W];
  assign hashHit     = hashTable[hashIdx];
  assign exactHit    = (addrQ == stationAddr);
  assign isGroup     = addrQ[0][0];
  assign isBroadcast = &addrQ;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN) !strobe.load |=> $stable(addrQ)); // R1
  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rstN) !strobe.load |=> $stable(crcQ)); // R4
  AST_LAST_LOADS: assert property (@(posedge clk) disable iff (!rstN) strobe.last |-> strobe.load); // R2
endmodule

// File: rtl/adf_decide.sv
module adf_decide
  import adf_pkg::*;
(
  input  adf_mode_t mode,
  input  logic      isGroup,
  input  logic      isBroadcast,
  input  logic      exactHit,
  input  logic      hashHit,
  output logic      accept
);
  always_comb begin
    accept = 1'b0;
    if (mode.promisc || isBroadcast) begin
      accept = 1'b1;
    end else if (isGroup) begin
      if (mode.allGroup) accept = 1'b1;
      else if (mode.hashPerfect || mode.hashOnly) accept = hashHit ^ mode.invert;
      else accept = 1'b0;
    end else if (mode.hashOnly) begin
      accept = hashHit ^ mode.invert;
    end else begin
      accept = exactHit ^ mode.invert;
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import adf_pkg::*;
#(
  parameter int unsigned ADDR_OCTETS = 6,
  parameter int unsigned HASH_WORD_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           octetValid,
  input  logic                           sofIn,
  input  logic [OCTET_W-1:0]             octetData,
  input  logic [ADDR_OCTETS*OCTET_W-1:0] stationAddr,
  input  logic [HASH_WORD_W-1:0]         hashHigh,
  input  logic [HASH_WORD_W-1:0]         hashLow,
  input  logic                           modePromisc,
  input  logic                           modeAllGroup,
  input  logic                           modeHashPerfect,
  input  logic                           modeHashOnly,
  input  logic                           modeInvert,
  output logic                           decisionValid,
  output logic                           decisionAccept
);
  adf_strobe_t strobe;
  adf_mode_t   mode;
  logic hashHit, exactHit, isGroup, isBroadcast, accept;

  assign mode = '{promisc: modePromisc, allGroup: modeAllGroup,
                  hashPerfect: modeHashPerfect, hashOnly: modeHashOnly,
                  invert: modeInvert};

  adf_ctrl #(.ADDR_OCTETS(ADDR_OCTETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .octetValid(octetValid), .sofIn(sofIn),
    .strobe(strobe), .decisionValid(decisionValid)
  );

  adf_datapath #(.ADDR_OCTETS(ADDR_OCTETS), .HASH_WORD_W(HASH_WORD_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .octetIn(octetData),
    .stationAddr(stationAddr), .hashHigh(hashHigh), .hashLow(hashLow),
    .hashHit(hashHit), .exactHit(exactHit), .isGroup(isGroup),
    .isBroadcast(isBroadcast)
  );

  adf_decide u_decide (
    .mode(mode), .isGroup(isGroup), .isBroadcast(isBroadcast),
    .exactHit(exactHit), .hashHit(hashHit), .accept(accept)
  );

  assign decisionAccept = decisionValid & accept;

  AST_VALID_AFTER_OCTET: assert property (@(posedge clk) disable iff (!rstN) decisionValid |-> $past(octetValid)); // R2
  AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rstN) !decisionValid |-> !decisionAccept); // R2
  AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rstN) (decisionValid && modePromisc) |-> decisionAccept); // R6
  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rstN) (decisionValid && isBroadcast) |-> decisionAccept); // R5
  AST_ALLGROUP_PASS: assert property (@(posedge clk) disable iff (!rstN) (decisionValid && isGroup && modeAllGroup) |-> decisionAccept); // R7
  AST_GROUP_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && isGroup && !isBroadcast && !modePromisc && !modeAllGroup && !modeHashPerfect && !modeHashOnly) |-> !decisionAccept); // R8
endmodule

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, octetValid, sofIn;
  logic [7:0] octetData;
  logic [47:0] stationAddr;
  logic [31:0] hashHigh, hashLow;
  logic [4:0] modeVec;
  logic decisionValid, decisionAccept;

  int checks = 0;
  int errors = 0;
  bit summaryDone = 1'b0;

  dest_addr_filter u_dest_addr_filter (
    .clk(clk), .rstN(rstN), .octetValid(octetValid), .sofIn(sofIn),
    .octetData(octetData), .stationAddr(stationAddr),
    .hashHigh(hashHigh), .hashLow(hashLow),
    .modePromisc(modeVec[0]), .modeAllGroup(modeVec[1]),
    .modeHashPerfect(modeVec[2]), .modeHashOnly(modeVec[3]),
    .modeInvert(modeVec[4]),
    .decisionValid(decisionValid), .decisionAccept(decisionAccept)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // R4 reference: shift register, bit 0 of each octet first
  function automatic logic [31:0] refCrc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic top = c[31] ^ a[8*k + b];
        c = c << 1;
        if (top) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c;
  endfunction

  function automatic logic [63:0] binMask(input logic [47:0] a);
    logic [5:0] idx = refCrc(a)[31:26];
    return 64'd1 << idx;
  endfunction

  function automatic logic refHit(input logic [47:0] a, input logic [31:0] hi, input logic [31:0] lo);
    logic [5:0] idx = refCrc(a)[31:26];
    return idx[5] ? hi[idx[4:0]] : lo[idx[4:0]];
  endfunction

  function automatic logic refAccept(input logic [47:0] a, input logic [4:0] m,
                                     input logic [31:0] hi, input logic [31:0] lo);
    logic grp = a[0];
    logic hit = refHit(a, hi, lo);
    if (m[0]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (grp) begin
      if (m[1]) return 1'b1;
      if (m[2] | m[3]) return hit ^ m[4];
      return 1'b0;
    end
    if (m[3]) return hit ^ m[4];
    return (a == stationAddr) ^ m[4];
  endfunction

  function automatic string reqTag(input logic [47:0] a, input logic [4:0] m);
    if (m[0]) return "R6";
    if (a == 48'hFFFF_FFFF_FFFF) return "R5";
    if (a[0] && m[1]) return "R7";
    if (m[4]) return "R11";
    if (m[3]) return "R10";
    if (m[2]) return "R9";
    return "R8";
  endfunction

  // Drive six octets, sof on octet 0; leaves the bench at the decision cycle
  task automatic sendAddr(input logic [47:0] a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      octetValid = 1'b1;
      sofIn = (k == 0);
      octetData = a[8*k +: 8];
    end
    @(negedge clk);
    octetValid = 1'b0;
    sofIn = 1'b0;
  endtask

  task automatic frameCheck(input logic [47:0] a, input string req);
    logic exp = refAccept(a, modeVec, hashHigh, hashLow);
    sendAddr(a);
    check({req, " valid"}, decisionValid, 1'b1);
    check(req, decisionAccept, exp);
    @(negedge clk);
    check("R2 pulse", decisionValid, 1'b0);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [47:0] addrs [5];
    logic [63:0] tbl;
    rstN = 1'b0; octetValid = 1'b0; sofIn = 1'b0; octetData = '0;
    stationAddr = 48'h5A4B_3C2D_1E02;
    hashHigh = '0; hashLow = '0; modeVec = '0;
    repeat (3) @(negedge clk);
    check("R12 valid", decisionValid, 1'b0);
    check("R12 accept", decisionAccept, 1'b0);
    rstN = 1'b1;

    // R1: octets with no preceding sof are ignored
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R1 no-sof", decisionValid, 1'b0);
      octetValid = 1'b1; octetData = stationAddr[8*(k%6) +: 8];
    end
    @(negedge clk);
    octetValid = 1'b0;
    check("R1 no-sof", decisionValid, 1'b0);

    addrs[0] = stationAddr;
    addrs[1] = stationAddr ^ 48'h0000_0100_0000;
    addrs[2] = 48'h0000_0000_5E01;
    addrs[3] = 48'h33CC_0055_AA03;
    addrs[4] = 48'hFFFF_FFFF_FFFF;

    // Sweep: every mode combination, address class and table shape
    for (int m = 0; m < 32; m++) begin
      for (int ai = 0; ai < 5; ai++) begin
        for (int t = 0; t < 4; t++) begin
          modeVec = 5'(m);
          case (t)
            0: tbl = '0;
            1: tbl = binMask(addrs[ai]);
            2: tbl = '1;
            default: tbl = ~binMask(addrs[ai]);
          endcase
          hashHigh = tbl[63:32]; hashLow = tbl[31:0];
          frameCheck(addrs[ai], reqTag(addrs[ai], 5'(m)));
        end
      end
    end

    // R4: single-bin scan over many group addresses
    modeVec = 5'b00100;
    for (int n = 0; n < 64; n++) begin
      logic [47:0] a = {8'(n * 37), 8'h11, 8'(n), 8'h00, 8'(n ^ 8'h5A), 8'h01};
      tbl = binMask(a);
      hashHigh = tbl[63:32]; hashLow = tbl[31:0];
      frameCheck(a, "R4 bin");
      tbl = ~binMask(a);
      hashHigh = tbl[63:32]; hashLow = tbl[31:0];
      frameCheck(a, "R4 other-bins");
    end

    // R3: restart mid-address
    modeVec = 5'b00000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      octetValid = 1'b1; sofIn = (k == 0); octetData = 8'hC3;
    end
    @(negedge clk);
    octetValid = 1'b0; sofIn = 1'b0;
    check("R3 partial", decisionValid, 1'b0);
    frameCheck(stationAddr, "R3 restart");

    // R1: trailing octets after the sixth produce nothing
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      octetValid = 1'b1; octetData = 8'hFF;
      check("R1 trailing", decisionValid, 1'b0);
    end
    @(negedge clk);
    octetValid = 1'b0;
    check("R1 trailing", decisionValid, 1'b0);
    @(negedge clk);
    check("R1 trailing", decisionValid, 1'b0);

    finishRun();
  end
endmodule